// File: doc/BRIEF.md
# Timer Event Flag Register with Selectable Interrupt Source

This block is an 8-bit status register that sits beside a timer. It holds two event flags and one source-select bit. One flag records a capture strobe from a neighbouring capture timer. The other flag records the end-of-processing strobe from a retriggerable one-shot tracker. The select bit decides which of the two sources may set its flag and raise the shared interrupt line. A strobe from the source that is not selected is dropped.

Software reaches the register through a plain read/write port. The read data always shows the current register contents. Asserting the read enable marks the cycle as a real read. A flag clears only through a handshake. Software must first read the flag while it is 1, and then write 0 to it. When a new event and a valid clearing write land on the same flag in the same cycle, the event wins. While the low-power input is high, both flags are held at 0.

Top module: `tmr_evt_flags`

## Requirements
- R1: Asserting reset (active low, asynchronous) drives the read data, both flags, the select bit and the interrupt to 0. They stay at 0 until the synchronised release.
- R2: Read data bit 2 is the select bit, bit 1 is the capture flag and bit 0 is the one-shot flag. Bits 7..3 always read 0, and writes to them have no effect.
- R3: With select = 0, a capture strobe sets the capture flag at the next clock edge. A one-shot strobe is ignored.
- R4: With select = 1, a one-shot strobe sets the one-shot flag at the next clock edge. A capture strobe is ignored.
- R5: Writing 0 to a flag clears it only if an earlier read (read enable high) returned that flag as 1, with no write to the register in between. Otherwise the flag keeps its value.
- R6: Writing 1 to a flag leaves it unchanged. Every write cancels any pending read-as-1 permission, so a later write of 0 without a new read does not clear.
- R7: When a set event and a valid clearing write hit the same flag in one cycle, the flag stays 1 and no interrupt pulse is produced.
- R8: The interrupt is a one-cycle pulse. It is high in the first cycle that the selected flag reads 1 after having been 0. A strobe that arrives while the flag is already 1 produces no pulse.
- R9: While the low-power input is high, both flags are forced to 0 at each clock edge, and strobes neither set a flag nor raise the interrupt.
- R10: The select bit is written from write-data bit 2 on every write. Changing it does not alter either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_mode | input | 1 | Low-power mode; holds both flags at 0 |
| cap_strobe | input | 1 | Capture event from the capture timer |
| os_end_strobe | input | 1 | End-of-processing event from the one-shot tracker |
| bus_re | input | 1 | Read enable; arms a flag that reads as 1 |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (select, capture flag, one-shot flag) |
| sel_os | output | 1 | Select bit: 0 selects capture, 1 selects one-shot end |
| cap_flag | output | 1 | Capture flag |
| os_flag | output | 1 | One-shot end flag |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The hardest case to reach from the ports is a set event landing in the same cycle as a clearing write that is actually allowed. For this, the flag must already be 1, it must have been read as 1, and no write may have happened since that read. The stimulus table sets the flag with a strobe and then issues a read. In the very next cycle it issues the zero-write and the strobe together. It then shows that the permission was used up: a second zero-write, with no new read, leaves the flag set. A separate sequence reads the flag while it is still 0, then sets it, then writes 0. This shows that a stale read gives no clearing permission.

// File: rtl/tef_pkg.sv
package tef_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_FLAGS = 2;
  // flag index equals its bit position in the register
  localparam int unsigned OS_POS    = 0;
  localparam int unsigned CAP_POS   = 1;
  localparam int unsigned SEL_POS   = 2;
  localparam int unsigned USED_W    = SEL_POS + 1;
endpackage

// File: rtl/tef_rst_sync.sv
module tef_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tef_flag_cell.sv
module tef_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic rise_o
);
  logic flag_q, flag_nxt, flag_en;
  logic arm_q, arm_nxt, arm_en;
  logic clr_ok;

  assign clr_ok = wr_i && !wbit_i && arm_q;

  always_comb begin
    flag_nxt = flag_q;
    flag_en  = 1'b0;
    if (lp_i) begin
      flag_nxt = 1'b0;
      flag_en  = 1'b1;
    end else if (set_i) begin
      flag_nxt = 1'b1;          // set wins over a clearing write
      flag_en  = 1'b1;
    end else if (clr_ok) begin
      flag_nxt = 1'b0;
      flag_en  = 1'b1;
    end
  end

  always_comb begin
    arm_nxt = arm_q;
    arm_en  = 1'b0;
    if (lp_i || wr_i) begin
      arm_nxt = 1'b0;
      arm_en  = 1'b1;
    end else if (rd_i && flag_q) begin
      arm_nxt = 1'b1;
      arm_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (flag_en) flag_q <= flag_nxt;
      if (arm_en)  arm_q  <= arm_nxt;
    end
  end

  assign flag_o = flag_q;
  assign rise_o = set_i && !flag_q && !lp_i;
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
  import tef_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_mode,
  input  logic             cap_strobe,
  input  logic             os_end_strobe,
  input  logic             bus_re,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             sel_os,
  output logic             cap_flag,
  output logic             os_flag,
  output logic             irq
);
  logic                 rst_int_n;
  logic                 sel_q, sel_nxt;
  logic                 irq_q, irq_nxt;
  logic [NUM_FLAGS-1:0] set_vec, flag_vec, rise_vec;
  logic                 unused_wbits;

  tef_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // source gating by the select bit
  always_comb begin
    set_vec          = '0;
    set_vec[CAP_POS] = cap_strobe && !sel_q;
    set_vec[OS_POS]  = os_end_strobe && sel_q;
  end

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    tef_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .lp_i   (lp_mode),
      .set_i  (set_vec[gi]),
      .rd_i   (bus_re),
      .wr_i   (bus_we),
      .wbit_i (bus_wdata[gi]),
      .flag_o (flag_vec[gi]),
      .rise_o (rise_vec[gi])
    );
  end

  assign sel_nxt = bus_we ? bus_wdata[SEL_POS] : sel_q;
  assign irq_nxt = |rise_vec;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (bus_we) sel_q <= sel_nxt;
      irq_q <= irq_nxt;
    end
  end

  always_comb begin
    bus_rdata                = '0;
    bus_rdata[NUM_FLAGS-1:0] = flag_vec;
    bus_rdata[SEL_POS]       = sel_q;
  end

  assign unused_wbits = ^bus_wdata[REG_W-1:USED_W];

  assign sel_os   = sel_q;
  assign cap_flag = flag_vec[CAP_POS];
  assign os_flag  = flag_vec[OS_POS];
  assign irq      = irq_q;
endmodule

// File: rtl/tmr_evt_flags_chk.sv
module tmr_evt_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lp_mode,
  input logic       cap_strobe,
  input logic       os_end_strobe,
  input logic [7:0] bus_rdata,
  input logic       sel_os,
  input logic       cap_flag,
  input logic       os_flag,
  input logic       irq
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:3] == 5'b0);

  a_r3_cap_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> $past(cap_strobe && !sel_os && !lp_mode));

  a_r4_os_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(os_flag) |-> $past(os_end_strobe && sel_os && !lp_mode));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && !sel_os && !lp_mode) |=> cap_flag);

  a_r7_set_wins_os: assert property (@(posedge clk) disable iff (!rst_n)
    (os_end_strobe && sel_os && !lp_mode) |=> os_flag);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r8_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($rose(cap_flag) || $rose(os_flag)));

  a_r9_lp_clears: assert property (@(posedge clk) disable iff (!rst_n)
    lp_mode |=> (!cap_flag && !os_flag && !irq));
endmodule

bind tmr_evt_flags tmr_evt_flags_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .lp_mode       (lp_mode),
  .cap_strobe    (cap_strobe),
  .os_end_strobe (os_end_strobe),
  .bus_rdata     (bus_rdata),
  .sel_os        (sel_os),
  .cap_flag      (cap_flag),
  .os_flag       (os_flag),
  .irq           (irq)
);

// File: tb/tmr_evt_flags_bench.sv
module tmr_evt_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lp_mode, cap_strobe, os_end_strobe, bus_re, bus_we;
  logic [7:0] bus_wdata, bus_rdata;
  logic       sel_os, cap_flag, os_flag, irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tmr_evt_flags u_tmr_evt_flags (
    .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .cap_strobe(cap_strobe),
    .os_end_strobe(os_end_strobe), .bus_re(bus_re), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel_os(sel_os),
    .cap_flag(cap_flag), .os_flag(os_flag), .irq(irq)
  );

  // {req[3:0], re, we, wdata[7:0], cap, os, lp, exp_rdata[7:0], exp_irq}
  function automatic logic [25:0] v(input logic [3:0] rq, input logic re,
      input logic we, input logic [7:0] wd, input logic cs, input logic os,
      input logic lp, input logic [7:0] er, input logic ei);
    return {rq, re, we, wd, cs, os, lp, er, ei};
  endfunction

  localparam int NV = 29;
  localparam logic [25:0] VEC [NV] = '{
    v(3,  0,0,8'h00, 1,0,0, 8'h02,1), // R3 capture sets flag, R8 pulse
    v(8,  0,0,8'h00, 0,0,0, 8'h02,0), // R8 pulse lasts one cycle
    v(8,  0,0,8'h00, 1,0,0, 8'h02,0), // R8 no pulse when already set
    v(3,  0,0,8'h00, 0,1,0, 8'h02,0), // R3 one-shot strobe ignored
    v(5,  0,1,8'h00, 0,0,0, 8'h02,0), // R5 clear without read
    v(5,  1,0,8'h00, 0,0,0, 8'h02,0), // R5 read arms
    v(6,  0,1,8'h02, 0,0,0, 8'h02,0), // R6 write 1 no effect
    v(6,  0,1,8'h00, 0,0,0, 8'h02,0), // R6 arm consumed
    v(5,  1,0,8'h00, 0,0,0, 8'h02,0), // R5 read arms
    v(5,  0,1,8'h00, 0,0,0, 8'h00,0), // R5 valid clear
    v(10, 0,1,8'h04, 0,0,0, 8'h04,0), // R10 select one-shot
    v(4,  0,0,8'h00, 1,0,0, 8'h04,0), // R4 capture ignored
    v(4,  0,0,8'h00, 0,1,0, 8'h05,1), // R4 one-shot sets, R8 pulse
    v(7,  1,0,8'h00, 0,0,0, 8'h05,0), // R7 read arms
    v(7,  0,1,8'h04, 0,1,0, 8'h05,0), // R7 set beats clear, no irq
    v(7,  0,1,8'h04, 0,0,0, 8'h05,0), // R7 arm used by collision
    v(2,  1,0,8'h00, 0,0,0, 8'h05,0), // R2 read arms
    v(2,  0,1,8'hFC, 0,0,0, 8'h04,0), // R2 upper bits ignored
    v(9,  0,0,8'h00, 0,1,1, 8'h04,0), // R9 strobe blocked in low power
    v(9,  0,0,8'h00, 0,1,0, 8'h05,1), // R9 set again after low power
    v(9,  0,0,8'h00, 0,0,1, 8'h04,0), // R9 forced clear
    v(10, 0,1,8'h00, 0,0,0, 8'h00,0), // R10 select capture
    v(3,  0,0,8'h00, 1,0,0, 8'h02,1), // R3 capture sets
    v(10, 0,1,8'h06, 0,0,0, 8'h06,0), // R10 select change keeps flag
    v(10, 1,0,8'h00, 0,0,0, 8'h06,0), // R10 read arms capture
    v(10, 0,1,8'h04, 0,0,0, 8'h04,0), // R10 clear under other select
    v(5,  1,0,8'h00, 0,0,0, 8'h04,0), // R5 read while flag 0
    v(5,  0,0,8'h00, 0,1,0, 8'h05,1), // R5 set after stale read
    v(5,  0,1,8'h04, 0,0,0, 8'h05,0)  // R5 stale read gives no clear
  };

  task automatic check(input int rq, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got 0x%02h expected 0x%02h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic re, input logic we, input logic [7:0] wd,
                     input logic cs, input logic os, input logic lp);
    @(negedge clk);
    bus_re = re; bus_we = we; bus_wdata = wd;
    cap_strobe = cs; os_end_strobe = os; lp_mode = lp;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    lp_mode = 0; cap_strobe = 0; os_end_strobe = 0;
    bus_re = 0; bus_we = 0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check(1, bus_rdata, 8'h00);                 // R1 reset state
    check(1, {7'b0, irq}, 8'h00);               // R1 irq low
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, 8'h00, 0, 0, 0);
    check(1, bus_rdata, 8'h00);                 // R1 after release

    for (int i = 0; i < NV; i++) begin
      logic [25:0] e;
      e = VEC[i];
      cyc(e[21], e[20], e[19:12], e[11], e[10], e[9]);
      check(int'(e[25:22]), bus_rdata, e[8:1]);
      check(int'(e[25:22]), {7'b0, irq}, {7'b0, e[0]});
      check(2, {5'b0, sel_os, cap_flag, os_flag}, e[8:1]); // R2 outputs match bits
    end

    // R1 asynchronous reset while a flag is set
    cyc(0, 0, 8'h00, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(1, bus_rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 strobe during synchronised release window is not taken
    cyc(0, 0, 8'h00, 1, 0, 0);
    check(1, bus_rdata, 8'h00);
    repeat (3) cyc(0, 0, 8'h00, 0, 0, 0);
    check(1, {bus_rdata[7:1], irq}, 8'h00);

    finish_run();
  end
endmodule